// File: doc/BRIEF.md
# Page-Write Nonvolatile Byte Store

This block models the write path of a byte-wide nonvolatile memory that the host drives like a static RAM. The host uses chip enable, output enable and write enable (all active low), an address and a byte of data. All of them are sampled on the system clock. Each write strobe latches its address and byte into an internal page buffer, so the host bus is free as soon as the strobe ends. A run of strobes fills the buffer with anywhere from one byte to a full page.

When no new strobe arrives within a programmable load window, the window closes and a self-timed commit copies every loaded slot into the register-based storage array. While the block is busy, reads return a polling byte. Its top bit is the inverse of the top bit of the last byte loaded, so the host sees completion when that bit reads true again. A separate 64-byte identification store occupies the top page of the address space. It is reached by holding a qualifier input high, and it is loaded and read the same way as the main array.

The default address width is 10 bits (1024 bytes), which keeps elaboration small. Setting it to 15 gives the full 32K x 8 organisation. The default load window and commit length are set for a 250 MHz clock: 150 us and 3 ms.

Top module: `ewp_page_eeprom`

## Requirements
- R1: After reset, busy_o is 0, data_oe_o is 0, data_o is 0, and every location of both stores reads 8'hFF.
- R2: A write event is a rising edge of we_ni, sampled on clk_i, while ce_ni is 0 and oe_ni is 1. That edge latches addr_i, data_i and id_sel_i. A we_ni edge with oe_ni at 0, or with ce_ni at 1, latches nothing and leaves busy_o at 0.
- R3: The page bits addr_i[ADDR_W-1:PAGE_W] of the first write event fix the target page for the whole load. Later events use only addr_i[PAGE_W-1:0] as the slot.
- R4: A slot loaded twice commits its last byte. Slots not loaded keep their previous array contents.
- R5: The load window closes LOAD_TIMEOUT cycles after the most recent write event. A new event that arrives before then restarts the window.
- R6: The commit lasts exactly COMMIT_CYCLES cycles. busy_o is high from the first write event through the end of the commit, which is LOAD_TIMEOUT + COMMIT_CYCLES cycles after the last event.
- R7: A read while busy_o is high returns the last loaded byte with its bit 7 inverted. Once busy_o is low, a read returns the stored byte.
- R8: Write events that occur during the commit are ignored. They change neither the buffer nor the array.
- R9: With id_sel_i at 1 and the page bits all ones, a load targets the 64-byte identification store and not the main array's top page. With id_sel_i at 1 on any other page, the load targets the main array.
- R10: A read is ce_ni=0, oe_ni=0 and we_ni=1. data_o and data_oe_o are registered: one cycle after a read cycle, data_oe_o is 1 and data_o holds the result. In any other cycle they are both 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low; the rising edge is the write event |
| id_sel_i | input | 1 | Qualifier that selects the identification store on the top page |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | DATA_W | Write data |
| data_o | output | DATA_W | Registered read data or polling byte |
| data_oe_o | output | 1 | Registered read-drive enable |
| busy_o | output | 1 | Load window open or commit in progress |

## Verification
The bench builds the block with a 10-bit address, 64-byte pages, an 8-cycle load window and an 80-cycle commit. These values make the load timeout, the exact busy length and the slot-by-slot commit short enough to measure cycle by cycle. With only 16 pages, random loads often land on the identification page and on pages already written, and they include repeated slots and stray upper address bits. Directed cases cover strobes at the edge of the window, strobes issued during the commit, and gated strobes.

// File: rtl/ewp_pkg.sv
package ewp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_COMMIT = 2'd2
  } ewp_state_e;
endpackage

// File: rtl/ewp_load_ctrl.sv
module ewp_load_ctrl
  import ewp_pkg::*;
#(
  parameter int PAGE_W        = 6,
  parameter int LOAD_TIMEOUT  = 37500,
  parameter int COMMIT_CYCLES = 750000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_evt_i,
  output ewp_state_e        state_o,
  output logic              load_first_o,
  output logic              load_more_o,
  output logic              commit_en_o,
  output logic [PAGE_W-1:0] commit_idx_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int LT_W = $clog2(LOAD_TIMEOUT + 1);
  localparam int CC_W = $clog2(COMMIT_CYCLES + 1);

  ewp_state_e      state_q;
  logic [LT_W-1:0] load_cnt_q;
  logic [CC_W-1:0] commit_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      load_cnt_q   <= '0;
      commit_cnt_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (wr_evt_i) begin
          state_q    <= ST_LOAD;
          load_cnt_q <= '0;
        end
        ST_LOAD: begin
          if (wr_evt_i) load_cnt_q <= '0;
          else if (load_cnt_q == LT_W'(LOAD_TIMEOUT - 1)) begin
            state_q      <= ST_COMMIT;
            commit_cnt_q <= '0;
          end else load_cnt_q <= load_cnt_q + 1'b1;
        end
        ST_COMMIT: begin
          if (commit_cnt_q == CC_W'(COMMIT_CYCLES - 1)) state_q <= ST_IDLE;
          else commit_cnt_q <= commit_cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o      = state_q;
  assign load_first_o = wr_evt_i && (state_q == ST_IDLE);
  assign load_more_o  = wr_evt_i && (state_q == ST_LOAD);
  // slot walk occupies the first PAGE_BYTES cycles of the commit
  assign commit_en_o  = (state_q == ST_COMMIT) && (commit_cnt_q < CC_W'(PAGE_BYTES));
  assign commit_idx_o = commit_cnt_q[PAGE_W-1:0];

  // checker: independent length counter for the commit phase
  logic [CC_W-1:0] chk_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_len_q <= '0;
    else if (state_q == ST_COMMIT) chk_len_q <= chk_len_q + 1'b1;
    else chk_len_q <= '0;
  end

  a_r6_commit_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && $past(state_q) == ST_COMMIT) |-> chk_len_q == CC_W'(COMMIT_CYCLES));
  a_r5_strobe_holds_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD && wr_evt_i) |=> state_q == ST_LOAD);
  a_r8_commit_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COMMIT) |=> state_q != ST_LOAD);
endmodule

// File: rtl/ewp_page_buf.sv
module ewp_page_buf #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_first_i,
  input  logic                     load_more_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        data_i,
  input  logic                     id_i,
  input  logic [PAGE_W-1:0]        rd_idx_i,
  output logic [ADDR_W-PAGE_W-1:0] base_o,
  output logic                     id_o,
  output logic                     slot_valid_o,
  output logic [DATA_W-1:0]        slot_data_o,
  output logic [DATA_W-1:0]        last_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int BASE_W = ADDR_W - PAGE_W;

  logic [PAGE_BYTES-1:0] valid_q;
  logic [DATA_W-1:0]     data_q [PAGE_BYTES];
  logic [BASE_W-1:0]     base_q;
  logic                  id_q;
  logic [DATA_W-1:0]     last_q;
  logic [PAGE_W-1:0]     slot;

  assign slot = addr_i[PAGE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      base_q  <= '0;
      id_q    <= 1'b0;
      last_q  <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) data_q[i] <= '0;
    end else if (load_first_i || load_more_i) begin
      if (load_first_i) begin
        base_q  <= addr_i[ADDR_W-1:PAGE_W];
        id_q    <= id_i;
        valid_q <= '0;
      end
      valid_q[slot] <= 1'b1;
      data_q[slot]  <= data_i;
      last_q        <= data_i;
    end
  end

  assign base_o       = base_q;
  assign id_o         = id_q;
  assign slot_valid_o = valid_q[rd_idx_i];
  assign slot_data_o  = data_q[rd_idx_i];
  assign last_o       = last_q;

  a_r3_page_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_more_i |=> ($stable(base_q) && $stable(id_q)));
  a_r8_buf_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_first_i || load_more_i) |=> ($stable(valid_q) && $stable(last_q)));
endmodule

// File: rtl/ewp_store.sv
module ewp_store #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              wr_id_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_id_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [DATA_W-1:0] main_q [DEPTH];
  logic [DATA_W-1:0] ident_q [PAGE_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) main_q[i] <= '1;
      for (int i = 0; i < PAGE_BYTES; i++) ident_q[i] <= '1;
    end else if (we_i) begin
      if (wr_id_i) ident_q[wr_addr_i[PAGE_W-1:0]] <= wr_data_i;
      else main_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = rd_id_i ? ident_q[rd_addr_i[PAGE_W-1:0]] : main_q[rd_addr_i];
endmodule

// File: rtl/ewp_page_eeprom.sv
module ewp_page_eeprom
  import ewp_pkg::*;
#(
  parameter int ADDR_W        = 10,
  parameter int DATA_W        = 8,
  parameter int PAGE_W        = 6,
  parameter int LOAD_TIMEOUT  = 37500,
  parameter int COMMIT_CYCLES = 750000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              id_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              busy_o
);
  localparam int BASE_W = ADDR_W - PAGE_W;

  ewp_state_e        state;
  logic              we_q, wr_evt, rd_en, id_hit;
  logic              load_first, load_more, commit_en;
  logic [PAGE_W-1:0] commit_idx;
  logic [BASE_W-1:0] base;
  logic              buf_id, slot_valid;
  logic [DATA_W-1:0] slot_data, last_byte, rd_data, poll_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_q <= 1'b1;
    else we_q <= we_ni;
  end

  assign wr_evt = !ce_ni && oe_ni && we_ni && !we_q;
  assign rd_en  = !ce_ni && !oe_ni && we_ni;
  assign id_hit = id_sel_i && (&addr_i[ADDR_W-1:PAGE_W]);

  ewp_load_ctrl #(
    .PAGE_W(PAGE_W), .LOAD_TIMEOUT(LOAD_TIMEOUT), .COMMIT_CYCLES(COMMIT_CYCLES)
  ) u_ctrl (
    .clk_i, .rst_ni, .wr_evt_i(wr_evt), .state_o(state),
    .load_first_o(load_first), .load_more_o(load_more),
    .commit_en_o(commit_en), .commit_idx_o(commit_idx)
  );

  ewp_page_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_buf (
    .clk_i, .rst_ni, .load_first_i(load_first), .load_more_i(load_more),
    .addr_i, .data_i, .id_i(id_hit), .rd_idx_i(commit_idx),
    .base_o(base), .id_o(buf_id), .slot_valid_o(slot_valid),
    .slot_data_o(slot_data), .last_o(last_byte)
  );

  ewp_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_store (
    .clk_i, .rst_ni, .we_i(commit_en && slot_valid), .wr_id_i(buf_id),
    .wr_addr_i({base, commit_idx}), .wr_data_i(slot_data),
    .rd_id_i(id_hit), .rd_addr_i(addr_i), .rd_data_o(rd_data)
  );

  assign busy_o    = (state != ST_IDLE);
  assign poll_byte = {~last_byte[DATA_W-1], last_byte[DATA_W-2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      data_oe_o <= 1'b0;
    end else begin
      data_oe_o <= rd_en;
      data_o    <= !rd_en ? '0 : (busy_o ? poll_byte : rd_data);
    end
  end

  a_r7_poll_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && busy_o) |=> data_o[DATA_W-1] == ~$past(last_byte[DATA_W-1]));
  a_r10_read_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en |=> data_oe_o);
  a_r10_idle_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |=> (data_o == '0 && !data_oe_o));
  a_r2_gated_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (ce_ni || !oe_ni)) |=> !busy_o);
endmodule

// File: tb/sim_ewp_page_eeprom.sv
module sim_ewp_page_eeprom;
  localparam int AW = 10, DW = 8, PW = 6, T = 8, C = 80;
  localparam int NPG = 1 << (AW - PW);

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1, id_sel = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic doe, busy;

  int n_chk = 0, n_fail = 0, cyc = 0;

  ewp_page_eeprom #(.ADDR_W(AW), .DATA_W(DW), .PAGE_W(PW),
                    .LOAD_TIMEOUT(T), .COMMIT_CYCLES(C)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .id_sel_i(id_sel), .addr_i(addr), .data_i(din), .data_o(dout),
    .data_oe_o(doe), .busy_o(busy));

  always #2 clk = ~clk;

  // model
  logic [7:0] mem_m [1 << AW];
  logic [7:0] id_m [64];
  logic       pg_open, pg_id;
  logic [AW-PW-1:0] pg_base;
  logic [63:0] pg_val;
  logic [7:0] pg_dat [64];
  logic [7:0] last_m;

  function automatic logic is_id(logic sel, logic [AW-1:0] a);
    return sel && (&a[AW-1:PW]);
  endfunction

  function automatic logic [7:0] exp_rd(logic sel, logic [AW-1:0] a);
    return is_id(sel, a) ? id_m[a[PW-1:0]] : mem_m[a];
  endfunction

  function automatic logic [7:0] poll_of(logic [7:0] b);
    return {~b[7], b[6:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_strobe(logic [AW-1:0] a, logic [7:0] d, logic sel);
    if (!pg_open) begin
      pg_open = 1; pg_base = a[AW-1:PW]; pg_id = is_id(sel, a); pg_val = '0;
    end
    pg_val[a[PW-1:0]] = 1'b1;
    pg_dat[a[PW-1:0]] = d;
    last_m = d;
  endtask

  task automatic model_commit();
    for (int s = 0; s < 64; s++) if (pg_val[s]) begin
      if (pg_id) id_m[s] = pg_dat[s];
      else mem_m[{pg_base, 6'(s)}] = pg_dat[s];
    end
    pg_open = 0;
  endtask

  task automatic wr_raw(logic [AW-1:0] a, logic [7:0] d, logic sel, logic ce_v, logic oe_v);
    @(negedge clk);
    ce_n = ce_v; oe_n = oe_v; we_n = 0; addr = a; din = d; id_sel = sel;
    @(negedge clk);
    we_n = 1;
    @(negedge clk);
    ce_n = 1; oe_n = 1; id_sel = 0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d, logic sel);
    wr_raw(a, d, sel, 1'b0, 1'b1);
    model_strobe(a, d, sel);
  endtask

  task automatic rd(logic [AW-1:0] a, logic sel, output logic [7:0] q, output logic oe_seen);
    @(negedge clk);
    ce_n = 0; oe_n = 0; we_n = 1; addr = a; id_sel = sel;
    @(negedge clk);
    q = dout; oe_seen = doe;
    ce_n = 1; oe_n = 1; id_sel = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    check("R6 busy clears", busy, 0);
    model_commit();
  endtask

  task automatic verify_page(logic [AW-PW-1:0] b, logic sel, string req);
    logic [7:0] q; logic o;
    for (int s = 0; s < 64; s++) begin
      rd({b, 6'(s)}, sel, q, o);
      check(req, q, exp_rd(sel, {b, 6'(s)}));
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected <150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] q; logic o;
    int n;
    void'($urandom(32'd20240611));
    for (int i = 0; i < (1 << AW); i++) mem_m[i] = 8'hFF;
    for (int i = 0; i < 64; i++) id_m[i] = 8'hFF;
    pg_open = 0; pg_id = 0; pg_base = '0; pg_val = '0; last_m = '0;
    for (int i = 0; i < 64; i++) pg_dat[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 data_oe", doe, 0);
    check("R1 data_o", dout, 0);
    rd(10'h005, 0, q, o); check("R1 erased main", q, 8'hFF);
    rd(10'h3C5, 1, q, o); check("R1 erased id", q, 8'hFF);

    // R10 bus idle after a read
    @(negedge clk);
    check("R10 oe drops", doe, 0);
    check("R10 data zero", dout, 0);
    rd(10'h006, 0, q, o); check("R10 oe during read", o, 1);

    // R2 gated strobes
    wr_raw(10'h010, 8'h11, 0, 1'b0, 1'b0);
    @(negedge clk); check("R2 oe low ignored", busy, 0);
    wr_raw(10'h010, 8'h22, 0, 1'b1, 1'b1);
    @(negedge clk); check("R2 ce high ignored", busy, 0);
    rd(10'h010, 0, q, o); check("R2 no change", q, 8'hFF);

    // R6 exact busy length for a single byte
    wr(10'h085, 8'hA5, 0);
    n = 0;
    for (int i = 0; i < 500 && busy; i++) begin n++; @(negedge clk); end
    check("R6 busy length", n, T + C);
    model_commit();
    rd(10'h085, 0, q, o); check("R7 true data after commit", q, 8'hA5);

    // R5/R3/R4 edge of window, stray upper bits, repeat slot
    wr(10'h0C1, 8'h10, 0);
    repeat (T - 3) @(negedge clk);
    wr(10'h205, 8'h20, 0);           // page from first byte, slot 5
    wr(10'h0C1, 8'h30, 0);           // slot 1 overwritten
    check("R5 window still open", busy, 1);
    rd(10'h000, 0, q, o); check("R7 poll byte", q, poll_of(8'h30));
    wait_idle();
    rd(10'h0C5, 0, q, o); check("R3 slot from later byte", q, 8'h20);
    rd(10'h205, 0, q, o); check("R3 other page untouched", q, 8'hFF);
    rd(10'h0C1, 0, q, o); check("R4 last value wins", q, 8'h30);
    rd(10'h0C2, 0, q, o); check("R4 unloaded slot kept", q, 8'hFF);

    // R8 strobes during commit
    wr(10'h081, 8'h5A, 0);
    repeat (T + 1) @(negedge clk);
    check("R8 in commit", busy, 1);
    wr_raw(10'h082, 8'h66, 0, 1'b0, 1'b1);
    wait_idle();
    rd(10'h082, 0, q, o); check("R8 commit strobe ignored", q, 8'hFF);
    rd(10'h081, 0, q, o); check("R8 loaded byte kept", q, 8'h5A);

    // R9 identification store
    wr(10'h3C3, 8'h3C, 1);
    wait_idle();
    rd(10'h3C3, 1, q, o); check("R9 id store written", q, 8'h3C);
    rd(10'h3C3, 0, q, o); check("R9 main top page untouched", q, 8'hFF);
    wr(10'h043, 8'h77, 1);
    wait_idle();
    rd(10'h043, 0, q, o); check("R9 qualifier off top page", q, 8'h77);
    rd(10'h043, 1, q, o); check("R9 qualifier off top page id", q, 8'h77);

    // random loads
    for (int t = 0; t < 30; t++) begin
      logic [AW-PW-1:0] b;
      logic sel;
      int nb;
      sel = (t % 5 == 0);
      b = sel ? '1 : (AW-PW)'($urandom % NPG);
      nb = 1 + ($urandom % 12);
      for (int i = 0; i < nb; i++) begin
        logic [AW-1:0] a;
        a = {(i == 0) ? b : (AW-PW)'($urandom), 6'($urandom % 64)};
        wr(a, 8'($urandom), sel);
        repeat ($urandom % (T - 2)) @(negedge clk);
      end
      rd(10'h000, 0, q, o);
      check("R7 random poll", q, poll_of(last_m));
      wait_idle();
      verify_page(b, sel, "R4 random page");
      begin
        logic [AW-1:0] a2;
        a2 = AW'($urandom);
        rd(a2, 0, q, o); check("R3 random other address", q, mem_m[a2]);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule